// File: doc/BRIEF.md
# Multi-line-selection row driver core

This block is the digital part of a cascadable LCD row driver for multi-line-selection addressing. A group shift register carries a selection token along the panel. Each register stage owns four adjacent rows. When a group is selected, all four of its rows are driven together with a signed pattern. Two pattern-select bits pick which of the four rows carries the odd sign. An AC polarity bit flips every sign of that pattern. Rows outside the selected groups rest at the centre level.

The line pulse is sampled by the system clock. A two-state machine watches it:
- `LN_WAIT_HIGH` moves to `LN_HIGH` when the pulse is seen high.
- `LN_HIGH` returns to `LN_WAIT_HIGH` when the pulse is seen low. That transition raises a one-cycle advance strobe.

Everything stateful moves only on that strobe: the shift register, the carry-out register, the pattern and polarity capture, and the row output register.

A direction pin sets which carry port is the input and which is the output, so several drivers can be chained. A mode pin narrows the active span to 100 rows. An active-low blanking input forces every row to the centre level at once and keeps all stored state.

Top module: `mls_row_driver`

## Requirements
- R1: A synchronous reset sets every row code to centre (00) and both carry outputs low.
- R2: State changes only on the clock edge at which the line pulse is first seen low after being seen high. While no such edge occurs, rows and carries hold, even when the other inputs change.
- R3: With `dir_rev` low, the value on `carry_a_i` enters the first active group at an advance. Each later advance moves it one group toward higher row numbers. At the advance after it sits in the last active group, it appears on `carry_b_o`. `carry_a_o` stays low in this direction.
- R4: With `dir_rev` high, the value on `carry_b_i` enters the last active group and moves toward lower row numbers. It leaves on `carry_a_o`, and `carry_b_o` stays low.
- R5: With `narrow_mode` high, only groups 2 to 26 are used (rows 9 to 108, rows numbered from 1). These are the first and last active groups. Rows 1 to 8 and 109 to 120 stay centre. With it low, groups 0 to 29 are used.
- R6: Group g covers rows 4g+1 to 4g+4. Row n sits at bits [2n-1:2n-2] of `row_drive`. The codes are 00 = centre, 01 = positive and 10 = negative. With polarity low, a selected group's four rows, in ascending row order, are:
  - (`pat_a`,`pat_b`) = (1,1): +,-,+,+
  - (0,1): +,+,-,+
  - (1,0): -,+,+,+
  - (0,0): +,+,+,-
- R7: With polarity high, every row of a selected group takes the opposite sign of its R6 level.
- R8: The polarity sampled at one advance applies to the rows produced at the next advance. The pattern bits sampled at an advance apply to the rows produced at that same advance.
- R9: A row whose group is not selected has code centre.
- R10: While `blank_n` is low, every row code is centre without waiting for a clock. Stored state is kept and still advances. On release, the rows show that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_pulse | input | 1 | Line pulse; its falling transition advances the block |
| dir_rev | input | 1 | Shift direction and carry-port role select |
| narrow_mode | input | 1 | High selects the 100-row span |
| pat_a | input | 1 | Pattern select bit A |
| pat_b | input | 1 | Pattern select bit B |
| ac_pol | input | 1 | AC polarity |
| blank_n | input | 1 | Blanking, active low, asynchronous to outputs |
| carry_a_i | input | 1 | Carry input on the low-row side |
| carry_b_i | input | 1 | Carry input on the high-row side |
| carry_a_o | output | 1 | Carry output on the low-row side |
| carry_b_o | output | 1 | Carry output on the high-row side |
| row_drive | output | 240 | Two-bit drive code per row |

## Verification
The embedded properties check these relations on every clock:
- the advance strobe never lasts two cycles;
- the shift register and carry register hold between advances;
- a full-span advance moves every stage by exactly one group in the chosen direction;
- narrow-mode advances leave the outer groups empty;
- a row group is non-centre exactly when its stage is set.

The exact sign patterns, the one-line polarity lag, the carry hand-off timing and the clock-free action of blanking can only be shown by the bench. It compares every row and carry against a model built from the requirements after each line pulse.

// File: rtl/mls_pkg.sv
package mls_pkg;

    typedef enum logic [1:0] {
        DRV_CENTRE = 2'b00,
        DRV_POS    = 2'b01,
        DRV_NEG    = 2'b10
    } drive_e;

    typedef enum logic {
        LN_WAIT_HIGH = 1'b0,
        LN_HIGH      = 1'b1
    } ln_state_e;

    localparam int unsigned ROWS_PER_GROUP = 4;

    // position inside a group of the row with the odd sign
    function automatic logic [1:0] odd_slot(input logic pa, input logic pb);
        logic [1:0] s;
        unique case ({pa, pb})
            2'b11:   s = 2'd1;
            2'b01:   s = 2'd2;
            2'b10:   s = 2'd0;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

    function automatic drive_e row_level(input logic sel, input logic [1:0] slot,
                                         input logic [1:0] odd, input logic pol);
        drive_e d;
        if (!sel)
            d = DRV_CENTRE;
        else if ((slot == odd) != pol)
            d = DRV_NEG;
        else
            d = DRV_POS;
        return d;
    endfunction

endpackage

// File: rtl/mls_line_edge.sv
module mls_line_edge
    import mls_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_pulse,
    output logic advance
);

    ln_state_e state_q;
    ln_state_e state_n;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LN_WAIT_HIGH;
        else
            state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        advance = 1'b0;
        unique case (state_q)
            LN_WAIT_HIGH: begin
                if (line_pulse)
                    state_n = LN_HIGH;
            end
            LN_HIGH: begin
                if (!line_pulse) begin
                    state_n = LN_WAIT_HIGH;
                    advance = 1'b1;
                end
            end
        endcase
    end

    AST_ADVANCE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        advance |=> !advance); // R2

endmodule

// File: rtl/mls_group_shift.sv
module mls_group_shift #(
    parameter int unsigned GROUPS    = 30,
    parameter int unsigned NARROW_LO = 2,
    parameter int unsigned NARROW_HI = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              dir_rev,
    input  logic              narrow_mode,
    input  logic              carry_in,
    output logic [GROUPS-1:0] sel_q,
    output logic [GROUPS-1:0] sel_n,
    output logic              carry_q
);

    localparam int unsigned FULL_LAST = GROUPS - 1;

    function automatic logic [GROUPS-1:0] outer_mask();
        logic [GROUPS-1:0] m;
        for (int g = 0; g < GROUPS; g++)
            m[g] = (g < NARROW_LO) || (g > NARROW_HI);
        return m;
    endfunction

    localparam logic [GROUPS-1:0] OUTER = outer_mask();

    int unsigned first_g;
    int unsigned last_g;
    logic        exit_bit;

    always_comb begin
        first_g  = narrow_mode ? NARROW_LO : 0;
        last_g   = narrow_mode ? NARROW_HI : FULL_LAST;
        exit_bit = dir_rev ? sel_q[first_g] : sel_q[last_g];
        for (int g = 0; g < GROUPS; g++) begin
            if (narrow_mode && OUTER[g])
                sel_n[g] = 1'b0;
            else if (!dir_rev)
                sel_n[g] = (g == first_g) ? carry_in : sel_q[(g == 0) ? 0 : g - 1];
            else
                sel_n[g] = (g == last_g) ? carry_in : sel_q[(g == FULL_LAST) ? FULL_LAST : g + 1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            carry_q <= 1'b0;
        end else if (advance) begin
            sel_q   <= sel_n;
            carry_q <= exit_bit;
        end
    end

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(sel_q) && $stable(carry_q))); // R2
    AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !dir_rev && !narrow_mode) |=> (sel_q[GROUPS-1:1] == $past(sel_q[GROUPS-2:0]))); // R3
    AST_REV_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && dir_rev && !narrow_mode) |=> (sel_q[GROUPS-2:0] == $past(sel_q[GROUPS-1:1]))); // R4
    AST_NARROW_OUTER: assert property (@(posedge clk) disable iff (rst)
        (advance && narrow_mode) |=> ((sel_q & OUTER) == '0)); // R5

endmodule

// File: rtl/mls_row_decode.sv
module mls_row_decode
    import mls_pkg::*;
#(
    parameter int unsigned GROUPS = 30
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   advance,
    input  logic [GROUPS-1:0]                      sel_n,
    input  logic                                   pat_a,
    input  logic                                   pat_b,
    input  logic                                   ac_pol,
    output logic [2*GROUPS*ROWS_PER_GROUP-1:0]     rows_q
);

    localparam int unsigned ROWS = GROUPS * ROWS_PER_GROUP;

    logic              pol_q;
    logic [1:0]        odd;
    logic [2*ROWS-1:0] rows_n;

    always_comb odd = odd_slot(pat_a, pat_b);

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            for (genvar r = 0; r < ROWS_PER_GROUP; r++) begin : g_row
                always_comb
                    rows_n[2*(g*ROWS_PER_GROUP+r) +: 2] = row_level(sel_n[g], 2'(r), odd, pol_q);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= 1'b0;
            rows_q <= '0;
        end else if (advance) begin
            pol_q  <= ac_pol;
            rows_q <= rows_n;
        end
    end

endmodule

// File: rtl/mls_row_driver.sv
module mls_row_driver
    import mls_pkg::*;
#(
    parameter int unsigned GROUPS    = 30,
    parameter int unsigned NARROW_LO = 2,
    parameter int unsigned NARROW_HI = 26
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                line_pulse,
    input  logic                                dir_rev,
    input  logic                                narrow_mode,
    input  logic                                pat_a,
    input  logic                                pat_b,
    input  logic                                ac_pol,
    input  logic                                blank_n,
    input  logic                                carry_a_i,
    input  logic                                carry_b_i,
    output logic                                carry_a_o,
    output logic                                carry_b_o,
    output logic [2*GROUPS*ROWS_PER_GROUP-1:0]  row_drive
);

    localparam int unsigned ROWS = GROUPS * ROWS_PER_GROUP;

    logic              advance;
    logic [GROUPS-1:0] grp_sel;
    logic [GROUPS-1:0] grp_sel_n;
    logic              carry_q;
    logic              carry_in;
    logic [2*ROWS-1:0] rows_q;

    always_comb carry_in = dir_rev ? carry_b_i : carry_a_i;

    mls_line_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .line_pulse (line_pulse),
        .advance    (advance)
    );

    mls_group_shift #(
        .GROUPS    (GROUPS),
        .NARROW_LO (NARROW_LO),
        .NARROW_HI (NARROW_HI)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance),
        .dir_rev     (dir_rev),
        .narrow_mode (narrow_mode),
        .carry_in    (carry_in),
        .sel_q       (grp_sel),
        .sel_n       (grp_sel_n),
        .carry_q     (carry_q)
    );

    mls_row_decode #(
        .GROUPS (GROUPS)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .sel_n   (grp_sel_n),
        .pat_a   (pat_a),
        .pat_b   (pat_b),
        .ac_pol  (ac_pol),
        .rows_q  (rows_q)
    );

    always_comb begin
        carry_a_o = dir_rev & carry_q;
        carry_b_o = ~dir_rev & carry_q;
        row_drive = blank_n ? rows_q : '0;
    end

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_chk
            AST_IDLE_GROUP_CENTRE: assert property (@(posedge clk) disable iff (rst)
                ((rows_q[2*ROWS_PER_GROUP*g +: 2*ROWS_PER_GROUP] == '0) == !grp_sel[g])); // R9
        end
    endgenerate

endmodule

// File: tb/sim_mls_row_driver.sv
module sim_mls_row_driver;

    localparam int G    = 30;
    localparam int ROWS = 120;
    localparam int NLO  = 2;
    localparam int NHI  = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_pulse = 1'b0;
    logic dir_rev = 1'b0;
    logic narrow_mode = 1'b0;
    logic pat_a = 1'b1;
    logic pat_b = 1'b1;
    logic ac_pol = 1'b0;
    logic blank_n = 1'b1;
    logic carry_a_i = 1'b0;
    logic carry_b_i = 1'b0;
    logic carry_a_o;
    logic carry_b_o;
    logic [2*ROWS-1:0] row_drive;

    int checks = 0;
    int errors = 0;

    logic [G-1:0]      sel_m;
    logic              carry_m;
    logic              pol_m;
    logic [2*ROWS-1:0] rows_m;

    always #5 clk = ~clk;

    mls_row_driver u0 (
        .clk(clk), .rst(rst), .line_pulse(line_pulse), .dir_rev(dir_rev),
        .narrow_mode(narrow_mode), .pat_a(pat_a), .pat_b(pat_b), .ac_pol(ac_pol),
        .blank_n(blank_n), .carry_a_i(carry_a_i), .carry_b_i(carry_b_i),
        .carry_a_o(carry_a_o), .carry_b_o(carry_b_o), .row_drive(row_drive)
    );

    function automatic logic [2*ROWS-1:0] exp_rows(input logic [G-1:0] s,
                                                   input logic pa, input logic pb, input logic pol);
        logic [2*ROWS-1:0] v;
        int ni;
        v = '0;
        case ({pa, pb})
            2'b11:   ni = 1;
            2'b01:   ni = 2;
            2'b10:   ni = 0;
            default: ni = 3;
        endcase
        for (int g = 0; g < G; g++)
            for (int r = 0; r < 4; r++)
                if (s[g])
                    v[2*(4*g+r) +: 2] = ((r == ni) != pol) ? 2'b10 : 2'b01;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [2*ROWS-1:0] act, input logic [2*ROWS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rows: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check_vec(req, row_drive, blank_n ? rows_m : '0);
        check_bit(req, "carry_a_o", carry_a_o, dir_rev & carry_m);
        check_bit(req, "carry_b_o", carry_b_o, ~dir_rev & carry_m);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_pulse = 1'b0; carry_a_i = 1'b0; carry_b_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        sel_m = '0; carry_m = 1'b0; pol_m = 1'b0; rows_m = '0;
    endtask

    // one line: inputs applied, pulse high, then low; sampled two negedges later
    task automatic pulse(input logic cin);
        int fi;
        int li;
        logic ex;
        @(negedge clk);
        if (dir_rev) carry_b_i = cin; else carry_a_i = cin;
        line_pulse = 1'b1;
        @(negedge clk);
        line_pulse = 1'b0;
        @(negedge clk);
        fi = narrow_mode ? NLO : 0;
        li = narrow_mode ? NHI : G - 1;
        ex = dir_rev ? sel_m[fi] : sel_m[li];
        if (!dir_rev) begin
            for (int g = li; g > fi; g--) sel_m[g] = sel_m[g-1];
            sel_m[fi] = cin;
        end else begin
            for (int g = fi; g < li; g++) sel_m[g] = sel_m[g+1];
            sel_m[li] = cin;
        end
        if (narrow_mode)
            for (int g = 0; g < G; g++)
                if (g < NLO || g > NHI) sel_m[g] = 1'b0;
        carry_m = ex;
        rows_m  = exp_rows(sel_m, pat_a, pat_b, pol_m);
        pol_m   = ac_pol;
    endtask

    task automatic t_reset();
        do_reset();
        check_vec("R1", row_drive, '0);
        check_bit("R1", "carry_a_o", carry_a_o, 1'b0);
        check_bit("R1", "carry_b_o", carry_b_o, 1'b0);
    endtask

    task automatic t_forward();
        do_reset();
        dir_rev = 1'b0; narrow_mode = 1'b0; pat_a = 1'b1; pat_b = 1'b1; ac_pol = 1'b0;
        pulse(1'b1);
        check_vec("R6", row_drive[7:0], 8'b01_01_10_01);
        check_vec("R9", row_drive[2*ROWS-1:8], '0);
        for (int i = 1; i < G; i++) begin
            pulse(1'b0);
            check_state("R3");
        end
        check_bit("R3", "token in last group", row_drive[2*ROWS-1 -: 8] != 8'h00, 1'b1);
        pulse(1'b0);
        check_bit("R3", "carry_b_o exit", carry_b_o, 1'b1);
        check_bit("R3", "carry_a_o idle", carry_a_o, 1'b0);
        pulse(1'b0);
        check_state("R3");
    endtask

    task automatic t_hold();
        do_reset();
        pulse(1'b1);
        pulse(1'b0);
        @(negedge clk);
        carry_a_i = 1'b1; pat_a = 1'b0; pat_b = 1'b0; ac_pol = 1'b1;
        line_pulse = 1'b1;
        repeat (4) @(negedge clk);
        check_state("R2");
        line_pulse = 1'b0;
        carry_a_i = 1'b0; pat_a = 1'b1; pat_b = 1'b1; ac_pol = 1'b0;
        // the pulse fell: one advance with the restored inputs
        @(negedge clk);
        @(negedge clk);
        sel_m = {sel_m[G-2:0], 1'b0};
        carry_m = 1'b0;
        rows_m = exp_rows(sel_m, 1'b1, 1'b1, pol_m);
        check_state("R2");
    endtask

    task automatic t_patterns();
        do_reset();
        dir_rev = 1'b0; narrow_mode = 1'b0; ac_pol = 1'b0;
        pat_a = 1'b0; pat_b = 1'b1;
        pulse(1'b1);
        check_vec("R6", row_drive[7:0], 8'b01_10_01_01);
        pat_a = 1'b1; pat_b = 1'b0;
        pulse(1'b0);
        check_vec("R6", row_drive[15:8], 8'b01_01_01_10);
        pat_a = 1'b0; pat_b = 1'b0; ac_pol = 1'b1;
        pulse(1'b0);
        check_vec("R8", row_drive[23:16], 8'b10_01_01_01);
        pat_a = 1'b1; pat_b = 1'b1;
        pulse(1'b0);
        check_vec("R7", row_drive[31:24], 8'b10_10_01_10);
        ac_pol = 1'b0;
        pulse(1'b0);
        check_vec("R7", row_drive[39:32], 8'b10_10_01_10);
        pulse(1'b0);
        check_vec("R8", row_drive[47:40], 8'b01_01_10_01);
        check_state("R6");
    endtask

    task automatic t_reverse();
        do_reset();
        dir_rev = 1'b1; narrow_mode = 1'b0; pat_a = 1'b1; pat_b = 1'b0; ac_pol = 1'b0;
        pulse(1'b1);
        check_vec("R4", row_drive[2*ROWS-1 -: 8], 8'b01_01_01_10);
        for (int i = 1; i < G; i++) begin
            pulse(1'b0);
            check_state("R4");
        end
        check_vec("R4", row_drive[7:0], 8'b01_01_01_10);
        pulse(1'b0);
        check_bit("R4", "carry_a_o exit", carry_a_o, 1'b1);
        check_bit("R4", "carry_b_o idle", carry_b_o, 1'b0);
        dir_rev = 1'b0;
    endtask

    task automatic t_narrow();
        do_reset();
        dir_rev = 1'b0; narrow_mode = 1'b1; pat_a = 1'b1; pat_b = 1'b1; ac_pol = 1'b0;
        pulse(1'b1);
        check_vec("R5", row_drive[23:16], 8'b01_01_10_01);
        check_vec("R5", {row_drive[2*ROWS-1:24], row_drive[15:0]}, '0);
        for (int i = 1; i < NHI - NLO + 1; i++) begin
            pulse(1'b0);
            check_state("R5");
        end
        check_vec("R5", row_drive[2*108-1 -: 8], 8'b01_01_10_01);
        pulse(1'b0);
        check_bit("R5", "carry_b_o exit", carry_b_o, 1'b1);
        check_vec("R5", row_drive, '0);
        dir_rev = 1'b1;
        pulse(1'b1);
        check_vec("R5", row_drive[2*108-1 -: 8], 8'b01_01_10_01);
        check_state("R5");
        dir_rev = 1'b0; narrow_mode = 1'b0;
    endtask

    task automatic t_blank();
        do_reset();
        dir_rev = 1'b0; narrow_mode = 1'b0; pat_a = 1'b0; pat_b = 1'b0; ac_pol = 1'b0;
        pulse(1'b1);
        pulse(1'b0);
        @(negedge clk);
        blank_n = 1'b0;
        #1;
        check_vec("R10", row_drive, '0);
        pulse(1'b0);
        check_vec("R10", row_drive, '0);
        @(negedge clk);
        blank_n = 1'b1;
        #1;
        check_vec("R10", row_drive, rows_m);
        check_vec("R10", row_drive[23:16], 8'b10_01_01_01);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_forward();
        t_hold();
        t_patterns();
        t_reverse();
        t_narrow();
        t_blank();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule